// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

The block is a watchdog that runs from its own slow low-speed clock, so it keeps counting when the main system clock stops. Software reaches it through a small write-only port in the bus clock domain that addresses three registers: a key register, a prescaler register and a reload register. Special key values start the watchdog, refresh it, or unlock the two configuration registers for writing. A static strap input can make the watchdog run from power-on without a start key. When the 8-bit down-counter expires, the block drives a reset pulse that a system reset controller consumes.

Each bus write is accepted with a valid/ready handshake. It is then carried into the low-speed domain by a toggle-synchronizer. `wr_ready` drops on the bus edge that accepts a write and stays low until the write has been applied in the low-speed domain and its acknowledge has come back. A master must hold `wr_valid`, `wr_addr` and `wr_data` steady until `wr_ready` is high. Nothing is lost under back-pressure, because the port never accepts a second write while one is in flight.

The counter clock is the low-speed clock divided by 2 and then by 2^(PR+2). A timeout therefore lasts 2·2^(PR+2)·(RLR+1) low-speed cycles, measured from the edge at which a refresh takes effect.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `wdg_rst` is low and `wr_ready` is high. The watchdog is stopped unless the strap is set. The prescaler field PR holds 0, the reload value RLR holds 0xFF, and the configuration is locked.
- R2: While the watchdog is stopped, `wdg_rst` never rises.
- R3: Writing 0xCC to the key register (address 0) starts a stopped watchdog with its counter at 0xFF and a fresh divider. The first pulse then comes 2·2^(PR+2)·256 low-speed cycles later. A 0xCC written while the watchdog runs leaves the count untouched.
- R4: Writing 0xAA to the key register loads the counter from RLR and restarts the divider. If no further refresh arrives, the counter expires and the pulse starts 2·2^(PR+2)·(RLR+1) low-speed cycles after the edge at which the refresh took effect. Between refreshes, the counter only holds or steps down by one.
- R5: Writes to the prescaler register (address 1, bits [2:0]) and to the reload register (address 2, bits [7:0]) are ignored unless the configuration is unlocked. Writes to address 3 are always ignored.
- R6: Writing 0x55 to the key register unlocks the configuration, and it stays unlocked across configuration writes. Any other key value locks it again. 0xAA both locks it and refreshes the counter.
- R7: A PR value of 7 divides like a PR of 6 (/256).
- R8: With the strap `hw_start` high through reset, the watchdog counts from 0xFF after reset without any start key.
- R9: Once running, no write stops the watchdog. After the counter expires, it reloads 0xFF and keeps counting.
- R10: Each expiry produces a `wdg_rst` pulse exactly 4 low-speed cycles long (parameter PULSE_LEN).
- R11: `wr_ready` is low from the accepting bus edge until the acknowledge returns. A write accepted within a low-speed period takes effect on the third following low-speed rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Bus clock for the write port |
| rst_bus_n | input | 1 | Asynchronous active-low reset, bus domain |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Port can accept a write |
| wr_addr | input | 2 | 0 key, 1 prescaler, 2 reload, 3 unused |
| wr_data | input | 8 | Write data |
| clk_lsi | input | 1 | Low-speed watchdog clock |
| rst_lsi_n | input | 1 | Asynchronous active-low reset, low-speed domain |
| hw_start | input | 1 | Static strap: run from power-on |
| wdg_rst | output | 1 | Watchdog reset pulse, low-speed domain |

## Verification
The bench targets the key interactions that are easy to get subtly wrong. One is a refresh sent while the configuration is unlocked, which must also lock it. Another is a foreign key value between an unlock and a reload write; a design that kept the unlock would shorten the next timeout. A third is a start key sent to an already running watchdog; a design that reloaded 0xFF would delay the pulse far past the expected cycle. The bench also reprograms the prescaler to a smaller divide while the divider phase sits beyond the new limit, where a design comparing only for equality would hang for a full divider wrap. Finally, it checks PR=7 against the /256 timing, and checks that expiry re-arms at 0xFF instead of stopping.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned BUS_DW = 8;
  localparam int unsigned BUS_AW = 2;

  typedef enum logic [BUS_AW-1:0] {
    SEL_KEY  = 2'd0,
    SEL_PRE  = 2'd1,
    SEL_RLD  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam logic [BUS_DW-1:0] KEY_START = 8'hCC;
  localparam logic [BUS_DW-1:0] KEY_KICK  = 8'hAA;
  localparam logic [BUS_DW-1:0] KEY_OPEN  = 8'h55;

  typedef struct packed {
    logic [BUS_AW-1:0] addr;
    logic [BUS_DW-1:0] data;
  } wr_rec_t;
endpackage

// File: rtl/wdg_xfer.sv
module wdg_xfer
  import wdg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_bus,
  input  logic              rst_bus_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BUS_AW-1:0] in_addr,
  input  logic [BUS_DW-1:0] in_data,
  input  logic              clk_lsi,
  input  logic              rst_lsi_n,
  output logic              out_pulse,
  output logic [BUS_AW-1:0] out_addr,
  output logic [BUS_DW-1:0] out_data
);
  logic                   req_q;
  wr_rec_t                hold_q;
  logic [SYNC_STAGES-1:0] ack_sync;
  logic [SYNC_STAGES-1:0] req_sync;
  logic                   seen_q;

  // bus side: one write in flight, held until its acknowledge returns
  assign in_ready = (req_q == ack_sync[SYNC_STAGES-1]);

  always_ff @(posedge clk_bus or negedge rst_bus_n) begin
    if (!rst_bus_n) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else if (in_valid && in_ready) begin
      req_q  <= ~req_q;
      hold_q <= '{addr: in_addr, data: in_data};
    end
  end

  always_ff @(posedge clk_bus or negedge rst_bus_n) begin
    if (!rst_bus_n) ack_sync <= '0;
    else            ack_sync <= {ack_sync[SYNC_STAGES-2:0], seen_q};
  end

  // low-speed side: synchronise the toggle, detect its change
  always_ff @(posedge clk_lsi or negedge rst_lsi_n) begin
    if (!rst_lsi_n) begin
      req_sync <= '0;
      seen_q   <= 1'b0;
    end else begin
      req_sync <= {req_sync[SYNC_STAGES-2:0], req_q};
      seen_q   <= req_sync[SYNC_STAGES-1];
    end
  end

  assign out_pulse = req_sync[SYNC_STAGES-1] ^ seen_q;
  assign out_addr  = hold_q.addr;
  assign out_data  = hold_q.data;
endmodule

// File: rtl/wdg_keys.sv
module wdg_keys
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_W = 3
) (
  input  logic              clk_lsi,
  input  logic              rst_lsi_n,
  input  logic              wr_vld,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [BUS_DW-1:0] wr_data,
  output logic              refresh_o,
  output logic              start_o,
  output logic              unlocked_o,
  output logic [PRE_W-1:0]  pr_o,
  output logic [CNT_W-1:0]  rlr_o
);
  logic key_wr;
  logic unl_q;

  assign key_wr     = wr_vld && (wr_addr == SEL_KEY);
  assign refresh_o  = key_wr && (wr_data == KEY_KICK);
  assign start_o    = key_wr && (wr_data == KEY_START);
  assign unlocked_o = unl_q;

  always_ff @(posedge clk_lsi or negedge rst_lsi_n) begin
    if (!rst_lsi_n) begin
      unl_q <= 1'b0;
      pr_o  <= '0;
      rlr_o <= '1;
    end else begin
      if (key_wr) unl_q <= (wr_data == KEY_OPEN);
      if (wr_vld && unl_q && (wr_addr == SEL_PRE)) pr_o  <= wr_data[PRE_W-1:0];
      if (wr_vld && unl_q && (wr_addr == SEL_RLD)) rlr_o <= wr_data[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PRE_W     = 3,
  parameter int unsigned PR_MAX    = 6,
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic             clk_lsi,
  input  logic             rst_lsi_n,
  input  logic             hw_start,
  input  logic             refresh,
  input  logic             start,
  input  logic [PRE_W-1:0] pr,
  input  logic [CNT_W-1:0] rlr,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wdg_rst_o
);
  // fixed /2 stage folded into the divider: phase length 2^(PR+3)
  localparam int unsigned DIV_W   = PR_MAX + 3;
  localparam int unsigned PULSE_W = $clog2(PULSE_LEN + 1);
  localparam logic [PRE_W-1:0] PR_CAP   = PRE_W'(PR_MAX);
  localparam logic [DIV_W-1:0] DIV_ONES = '1;

  logic               run_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [DIV_W-1:0]   div_q;
  logic [PULSE_W-1:0] pulse_q;
  logic [PRE_W-1:0]   pr_eff;
  logic [DIV_W-1:0]   div_last;
  logic               tick;
  logic               fire;

  assign run_o    = run_q | hw_start;
  assign pr_eff   = (pr > PR_CAP) ? PR_CAP : pr;
  assign div_last = DIV_ONES >> (PR_CAP - pr_eff);
  assign tick     = run_o && (div_q >= div_last);
  assign fire     = tick && !refresh && (cnt_q == '0);

  always_ff @(posedge clk_lsi or negedge rst_lsi_n) begin
    if (!rst_lsi_n) begin
      run_q <= 1'b0;
      cnt_q <= '1;
      div_q <= '0;
    end else begin
      if (start) run_q <= 1'b1;
      if (refresh) begin
        cnt_q <= rlr;
        div_q <= '0;
      end else if (start && !run_o) begin
        cnt_q <= '1;
        div_q <= '0;
      end else if (tick) begin
        div_q <= '0;
        cnt_q <= (cnt_q == '0) ? '1 : cnt_q - 1'b1;
      end else if (run_o) begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_lsi or negedge rst_lsi_n) begin
    if (!rst_lsi_n)          pulse_q <= '0;
    else if (fire)           pulse_q <= PULSE_W'(PULSE_LEN);
    else if (pulse_q != '0)  pulse_q <= pulse_q - 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign wdg_rst_o = (pulse_q != '0);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PRE_W       = 3,
  parameter int unsigned PR_MAX      = 6,
  parameter int unsigned PULSE_LEN   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_bus,
  input  logic              rst_bus_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [BUS_DW-1:0] wr_data,
  input  logic              clk_lsi,
  input  logic              rst_lsi_n,
  input  logic              hw_start,
  output logic              wdg_rst
);
  logic              x_vld;
  logic [BUS_AW-1:0] x_addr;
  logic [BUS_DW-1:0] x_data;
  logic              refresh;
  logic              start;
  logic              unlocked;
  logic [PRE_W-1:0]  pr;
  logic [CNT_W-1:0]  rlr;
  logic              run;
  logic [CNT_W-1:0]  cnt;

  wdg_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n),
    .in_valid(wr_valid), .in_ready(wr_ready),
    .in_addr(wr_addr), .in_data(wr_data),
    .clk_lsi(clk_lsi), .rst_lsi_n(rst_lsi_n),
    .out_pulse(x_vld), .out_addr(x_addr), .out_data(x_data)
  );

  wdg_keys #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_keys (
    .clk_lsi(clk_lsi), .rst_lsi_n(rst_lsi_n),
    .wr_vld(x_vld), .wr_addr(x_addr), .wr_data(x_data),
    .refresh_o(refresh), .start_o(start), .unlocked_o(unlocked),
    .pr_o(pr), .rlr_o(rlr)
  );

  wdg_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PR_MAX(PR_MAX),
                .PULSE_LEN(PULSE_LEN)) u_cnt (
    .clk_lsi(clk_lsi), .rst_lsi_n(rst_lsi_n), .hw_start(hw_start),
    .refresh(refresh), .start(start), .pr(pr), .rlr(rlr),
    .run_o(run), .cnt_o(cnt), .wdg_rst_o(wdg_rst)
  );
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_bus,
  input logic             rst_bus_n,
  input logic             clk_lsi,
  input logic             rst_lsi_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             wdg_rst,
  input logic             run,
  input logic             refresh,
  input logic             x_vld,
  input logic [1:0]       x_addr,
  input logic             unlocked,
  input logic [CNT_W-1:0] rlr,
  input logic [CNT_W-1:0] cnt
);
  assert_accept_blocks_R11: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (wr_valid && wr_ready) |=> !wr_ready);

  assert_pulse_width_R10: assert property (@(posedge clk_lsi) disable iff (!rst_lsi_n)
    $rose(wdg_rst) |=> wdg_rst);

  assert_run_sticky_R9: assert property (@(posedge clk_lsi) disable iff (!rst_lsi_n)
    run |=> run);

  assert_rst_needs_run_R2: assert property (@(posedge clk_lsi) disable iff (!rst_lsi_n)
    wdg_rst |-> run);

  assert_count_step_R4: assert property (@(posedge clk_lsi) disable iff (!rst_lsi_n)
    (run && !refresh && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

  assert_locked_rlr_R5: assert property (@(posedge clk_lsi) disable iff (!rst_lsi_n)
    (x_vld && !unlocked && x_addr == 2'd2) |=> $stable(rlr));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_lsi(clk_lsi), .rst_lsi_n(rst_lsi_n),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wdg_rst(wdg_rst), .run(run),
  .refresh(refresh), .x_vld(x_vld), .x_addr(x_addr), .unlocked(unlocked),
  .rlr(rlr), .cnt(cnt)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LSI_RATIO  = 8;
  localparam int PULSE      = 4;

  logic       clk_bus = 1'b0, clk_lsi = 1'b0;
  logic       rst_bus_n = 1'b0, rst_lsi_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       hw_start = 1'b0;
  logic       wr_ready, wdg_rst;

  keyed_watchdog u_dut (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .clk_lsi(clk_lsi), .rst_lsi_n(rst_lsi_n),
    .hw_start(hw_start), .wdg_rst(wdg_rst)
  );

  always #(CLK_PERIOD/2) clk_bus = ~clk_bus;
  always #(CLK_PERIOD*LSI_RATIO/2) clk_lsi = ~clk_lsi;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { int at; int a; int d; } pend_t;
  pend_t q[$];
  int  edge_cnt = 0;
  bit  m_run = 0, m_unl = 0;
  int  m_cnt = 255, m_ph = 0, m_pr = 0, m_rlr = 255, m_pulse = 0;

  function automatic int phase_len(input int pr);
    int p;
    p = (pr > 6) ? 6 : pr;
    return 2 * (1 << (p + 2));
  endfunction

  always @(posedge clk_lsi) begin
    bit rf, st, fire, run_now;
    int n_pr, n_rlr;
    bit n_unl;
    pend_t r;
    edge_cnt++;
    if (!rst_lsi_n) begin
      m_run = 0; m_unl = 0; m_cnt = 255; m_ph = 0; m_pr = 0; m_rlr = 255; m_pulse = 0;
    end else begin
      rf = 0; st = 0; fire = 0;
      n_pr = m_pr; n_rlr = m_rlr; n_unl = m_unl;
      if (q.size() > 0 && q[0].at == edge_cnt) begin
        r = q.pop_front();
        if (r.a == 0) begin
          rf = (r.d == 8'hAA); st = (r.d == 8'hCC); n_unl = (r.d == 8'h55);
        end else if (r.a == 1 && m_unl) n_pr = r.d % 8;
        else if (r.a == 2 && m_unl) n_rlr = r.d;
      end
      run_now = m_run || hw_start;
      if (rf) begin m_cnt = m_rlr; m_ph = 0; end
      else if (st && !run_now) begin m_cnt = 255; m_ph = 0; end
      else if (run_now) begin
        if (m_ph >= phase_len(m_pr) - 1) begin
          m_ph = 0;
          if (m_cnt == 0) begin fire = 1; m_cnt = 255; end
          else m_cnt--;
        end else m_ph++;
      end
      if (fire) m_pulse = PULSE;
      else if (m_pulse > 0) m_pulse--;
      if (st) m_run = 1;
      m_pr = n_pr; m_rlr = n_rlr; m_unl = n_unl;
    end
  end

  // compare a quarter period after each low-speed edge
  always @(posedge clk_lsi) begin
    #(CLK_PERIOD*LSI_RATIO/4);
    if (rst_lsi_n && !done)
      check(wdg_rst === (m_pulse > 0), cur_req, "wdg_rst", int'(wdg_rst), int'(m_pulse > 0));
  end

  // ---------------- stimulus ----------------
  task automatic lsi_wait(input int n);
    repeat (n) @(posedge clk_lsi);
  endtask

  task automatic bus_write(input int a, input int d);
    @(posedge clk_lsi); #1;
    check(wr_ready === 1'b1, "R11", "wr_ready before write", int'(wr_ready), 1);
    q.push_back('{at: edge_cnt + 3, a: a, d: d});
    wr_valid = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    @(posedge clk_bus); #1;
    wr_valid = 1'b0;
    check(wr_ready === 1'b0, "R11", "wr_ready while pending", int'(wr_ready), 0);
    while (wr_ready !== 1'b1) begin @(posedge clk_bus); #1; end
  endtask

  task automatic do_reset(input bit strap);
    @(negedge clk_lsi);
    rst_bus_n = 1'b0; rst_lsi_n = 1'b0; hw_start = strap;
    q.delete();
    repeat (3) @(negedge clk_lsi);
    rst_bus_n = 1'b1; rst_lsi_n = 1'b1;
  endtask

  initial begin
    repeat (180000) @(posedge clk_bus);
    if (!done) begin
      done = 1;
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    @(negedge clk_lsi);
    cur_req = "R1";
    check(wr_ready === 1'b1, "R1", "wr_ready after reset", int'(wr_ready), 1);
    check(wdg_rst === 1'b0, "R1", "wdg_rst after reset", int'(wdg_rst), 0);

    cur_req = "R2";            // stopped watchdog never fires
    lsi_wait(700);

    cur_req = "R5";            // locked reload write, address 3 write
    bus_write(2, 3);
    bus_write(3, 0);

    cur_req = "R3";            // start: 0xFF at /4 -> 2048 cycles
    bus_write(0, 8'hCC);
    lsi_wait(2100);

    cur_req = "R9";            // re-armed at 0xFF, refresh keeps default reload
    bus_write(0, 8'hAA);
    lsi_wait(100);

    cur_req = "R4";            // unlock, reload 3 -> 32 cycle timeout
    bus_write(0, 8'h55);
    bus_write(1, 0);
    bus_write(2, 3);
    bus_write(0, 8'hAA);
    lsi_wait(40);
    for (int i = 0; i < 6; i++) begin
      bus_write(0, 8'hAA);
      lsi_wait(12);
    end

    cur_req = "R6";            // foreign key locks again
    bus_write(0, 8'h55);
    bus_write(0, 8'h00);
    bus_write(2, 0);
    bus_write(0, 8'hAA);
    lsi_wait(40);
    bus_write(0, 8'h55);       // refresh while unlocked locks too
    bus_write(0, 8'hAA);
    bus_write(2, 0);
    bus_write(0, 8'hAA);
    lsi_wait(40);

    cur_req = "R7";            // PR 7 behaves as /256
    bus_write(0, 8'h55);
    bus_write(1, 7);
    bus_write(2, 0);
    bus_write(0, 8'hAA);
    lsi_wait(560);

    cur_req = "R3";            // start key while running: no reload
    bus_write(0, 8'h55);
    bus_write(1, 2);
    bus_write(2, 1);
    bus_write(0, 8'hAA);
    lsi_wait(20);
    bus_write(0, 8'hCC);
    lsi_wait(60);

    cur_req = "R4";            // shrink prescaler mid-phase
    bus_write(0, 8'hAA);
    lsi_wait(25);
    bus_write(0, 8'h55);
    bus_write(1, 0);
    lsi_wait(60);

    cur_req = "R9";            // no key stops it
    bus_write(0, 8'h00);
    bus_write(0, 8'hFF);
    lsi_wait(80);

    cur_req = "R10";           // pulse width across several expiries
    bus_write(0, 8'hAA);
    lsi_wait(120);

    cur_req = "R8";            // strap: runs from reset, 2048 cycles
    do_reset(1'b1);
    @(negedge clk_lsi);
    check(wdg_rst === 1'b0, "R8", "wdg_rst after strap reset", int'(wdg_rst), 0);
    lsi_wait(2100);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule